// File: doc/BRIEF.md
# Tiered Weighted Round-Robin Bus Arbiter

This block decides which of several bus masters owns a shared bus. Masters are grouped into strict priority tiers; inside a tier they take turns in index order, and each turn lasts for up to a programmable number of transactions (the master's weight). The default build has six masters: a processor (index 0) and a first transfer engine (index 1) in the top tier, three further transfer engines (indices 2 to 4) in the middle tier, and a diagnostic port (index 5) in the bottom tier. The default weights are 4, 2, 1, 1, 1, 1 in index order.

Masters raise a level request and keep it high while they want the bus. The fabric pulses `bus_free_i` when the current transaction ends. Only on such a pulse, with at least one request pending, is an arbitration decision taken; the result appears on the registered one-hot grant on the next clock edge. A tier that has given one turn to each of its requesters steps aside, so lower tiers are served before the top tier starts a new round. With all masters except the diagnostic port requesting, the grant sequence over successive bus-free pulses is processor four times, first engine twice, then engines 2, 3 and 4 once each, repeating.

Weights are set through a simple write port; reset restores the defaults.

Top module: `wrr_tier_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set in every cycle.
- R2: `grant_o` moves to a different master only on the clock edge that samples `bus_free_i` high with at least one request pending; without that, the grant either stays as it was or is cleared.
- R3: A grant issued by a decision always goes to a master whose request was high in the deciding cycle, and a decision never leaves the grant empty.
- R4: If the granted master lowers its request in a cycle without `bus_free_i`, `grant_o` is all zero after the next edge.
- R5: A master that keeps requesting holds the grant for exactly as many consecutive decisions as its weight, unless a higher tier takes over.
- R6: Within a tier, turns rotate in ascending master index from the master after the one last granted in that tier, skipping idle masters; with masters 0 to 4 requesting and default weights the decision sequence is 0,0,0,0,1,1,2,3,4 repeated, and with all six requesting it is 0,0,0,0,1,1,2,3,4,5 repeated.
- R7: At a decision, a requesting tier above the owner's tier that has not finished its round takes the bus even if the owner has weight left.
- R8: A master that drops its request before its weight is used loses the rest of its turn; the next decision in its tier goes to the next master in rotation.
- R9: Each tier keeps its own rotation position; serving other tiers does not change where a tier resumes.
- R10: Weights are 4-bit values; a write with the enable high, an index below the master count and a non-zero value sets that master's weight from the next edge; a zero value or an index of 6 or more is ignored.
- R11: Synchronous reset (`rst` high) clears the grant, loads the default weights, and sets every tier to start its rotation at its lowest-index master.
- R12: When a tier grants the last requester in its rotation order, it counts as finished for the round; decisions then skip finished tiers, and when every requesting tier is finished all tiers are reopened and the highest requesting tier is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 6 | Bus request, one bit per master |
| bus_free_i | input | 1 | Pulse: the current transaction has ended |
| cfg_we_i | input | 1 | Weight write enable |
| cfg_idx_i | input | 4 | Master index of the weight write |
| cfg_wdata_i | input | 4 | New weight value |
| grant_o | output | 6 | One-hot bus grant |

## Verification
On every cycle the assertions watch the one-hot shape of the grant, that the grant only moves after a bus-free decision, that a decision grants a master that was asking, that a dropped request clears the grant, that an open top tier always wins a decision, and that no weight register holds zero. The weight-driven turn lengths, the rotation order inside each tier, the forfeit of unused credit, the independent tier positions and the round completion rule depend on histories of many decisions, so they are shown by the directed sequences and by the bench's reference model during the random phase.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;

    localparam int MAX_MASTERS = 16;
    localparam int TIER_BITS   = 2;
    localparam int WGT_BITS    = 4;
    localparam int IDX_BITS    = 4;

    // Default layout: masters 0,1 -> tier 0; 2,3,4 -> tier 1; 5 -> tier 2
    localparam logic [MAX_MASTERS*TIER_BITS-1:0] DEF_TIER_MAP = 32'h0000_0950;
    // Default weights: 4,2,1,1,1,1 for masters 0..5
    localparam logic [MAX_MASTERS*WGT_BITS-1:0]  DEF_WEIGHTS  = 64'h0000_0000_0011_1124;

    typedef logic [WGT_BITS-1:0] weight_t;
    typedef logic [IDX_BITS-1:0] midx_t;

    typedef struct packed {
        logic  any;   // some master of the tier is requesting
        midx_t win;   // next master of the tier in rotation
        logic  last;  // win is the final requester before the rotation wraps
    } tier_pick_t;

    function automatic int tier_of(input logic [MAX_MASTERS*TIER_BITS-1:0] map, input int m);
        return int'(map[m*TIER_BITS +: TIER_BITS]);
    endfunction

    function automatic int last_of_tier(input logic [MAX_MASTERS*TIER_BITS-1:0] map,
                                        input int n, input int t);
        int r;
        r = 0;
        for (int m = 0; m < n; m++) begin
            if (tier_of(map, m) == t) r = m;
        end
        return r;
    endfunction

    function automatic logic [MAX_MASTERS-1:0] tier_mask(
        input logic [MAX_MASTERS*TIER_BITS-1:0] map, input int t);
        logic [MAX_MASTERS-1:0] r;
        for (int m = 0; m < MAX_MASTERS; m++) begin
            r[m] = (tier_of(map, m) == t);
        end
        return r;
    endfunction

endpackage

// File: rtl/wrr_weight_regs.sv
module wrr_weight_regs
    import wrr_arb_pkg::*;
#(
    parameter int N_MASTERS = 6,
    parameter logic [MAX_MASTERS*WGT_BITS-1:0] WEIGHTS_INIT = DEF_WEIGHTS
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  midx_t                             wr_idx,
    input  weight_t                           wr_val,
    output logic [N_MASTERS-1:0][WGT_BITS-1:0] wgt_o
);

    generate
        for (genvar i = 0; i < N_MASTERS; i++) begin : g_wgt
            always_ff @(posedge clk) begin
                if (rst) begin
                    wgt_o[i] <= WEIGHTS_INIT[i*WGT_BITS +: WGT_BITS];
                end else if (wr_en && wr_idx == IDX_BITS'(i) && wr_val != '0) begin
                    wgt_o[i] <= wr_val;
                end
            end

            // R10
            always_ff @(posedge clk) begin
                if (!rst) begin
                    weight_nonzero_chk: assert (wgt_o[i] != '0)
                        else $error("weight of master %0d is zero", i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wrr_tier_pick.sv
module wrr_tier_pick
    import wrr_arb_pkg::*;
#(
    parameter int N_MASTERS = 6,
    parameter int TIER_ID   = 0,
    parameter logic [MAX_MASTERS*TIER_BITS-1:0] TIER_MAP = DEF_TIER_MAP
) (
    input  logic [N_MASTERS-1:0] req,
    input  midx_t                ptr,
    output tier_pick_t           pick
);

    always_comb begin
        int c;
        pick = '0;
        // search forward from the master after the last one served
        for (int off = 1; off <= N_MASTERS; off++) begin
            c = (int'(ptr) + off) % N_MASTERS;
            if (!pick.any && req[c] && tier_of(TIER_MAP, c) == TIER_ID) begin
                pick.any = 1'b1;
                pick.win = IDX_BITS'(c);
            end
        end
        // the rotation wraps after win when no higher-index requester remains
        pick.last = 1'b1;
        for (int m = 0; m < N_MASTERS; m++) begin
            if (req[m] && tier_of(TIER_MAP, m) == TIER_ID && m > int'(pick.win)) begin
                pick.last = 1'b0;
            end
        end
    end

endmodule

// File: rtl/wrr_tier_arbiter.sv
module wrr_tier_arbiter
    import wrr_arb_pkg::*;
#(
    parameter int N_MASTERS = 6,
    parameter int N_TIERS   = 3,
    parameter logic [MAX_MASTERS*TIER_BITS-1:0] TIER_MAP     = DEF_TIER_MAP,
    parameter logic [MAX_MASTERS*WGT_BITS-1:0]  WEIGHTS_INIT = DEF_WEIGHTS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 bus_free_i,
    input  logic                 cfg_we_i,
    input  logic [IDX_BITS-1:0]  cfg_idx_i,
    input  logic [WGT_BITS-1:0]  cfg_wdata_i,
    output logic [N_MASTERS-1:0] grant_o
);

    localparam logic [N_MASTERS-1:0] TOP_MASK = N_MASTERS'(tier_mask(TIER_MAP, 0));

    logic [N_MASTERS-1:0][WGT_BITS-1:0] wgt;
    logic [N_TIERS-1:0][IDX_BITS-1:0]   ptr_q;
    logic [N_TIERS-1:0]                 spent_q, spent_nx;
    tier_pick_t                         picks [N_TIERS];
    logic [N_TIERS-1:0]                 t_any, t_elig, cand;
    midx_t                              own_q, win;
    logic                               own_vld_q;
    weight_t                            used_q;
    logic                               decide, keep, higher_elig, fresh;
    int                                 sel_t, own_tier;

    wrr_weight_regs #(
        .N_MASTERS   (N_MASTERS),
        .WEIGHTS_INIT(WEIGHTS_INIT)
    ) u_wgt (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_we_i),
        .wr_idx(cfg_idx_i),
        .wr_val(cfg_wdata_i),
        .wgt_o (wgt)
    );

    generate
        for (genvar t = 0; t < N_TIERS; t++) begin : g_tier
            wrr_tier_pick #(
                .N_MASTERS(N_MASTERS),
                .TIER_ID  (t),
                .TIER_MAP (TIER_MAP)
            ) u_pick (
                .req (req_i),
                .ptr (ptr_q[t]),
                .pick(picks[t])
            );
            assign t_any[t]  = picks[t].any;
            assign t_elig[t] = picks[t].any & ~spent_q[t];
        end
    endgenerate

    always_comb begin
        own_tier    = tier_of(TIER_MAP, int'(own_q));
        higher_elig = 1'b0;
        for (int t = 0; t < N_TIERS; t++) begin
            if (t < own_tier && t_elig[t]) higher_elig = 1'b1;
        end
        decide = bus_free_i && (|req_i);
        keep   = own_vld_q && req_i[own_q] && (used_q < wgt[own_q]) && !higher_elig;

        fresh = ~(|t_elig);
        cand  = fresh ? t_any : t_elig;
        sel_t = 0;
        for (int t = N_TIERS - 1; t >= 0; t--) begin
            if (cand[t]) sel_t = t;
        end
        win      = picks[sel_t].win;
        spent_nx = fresh ? '0 : spent_q;
        spent_nx[sel_t] = spent_nx[sel_t] | picks[sel_t].last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o   <= '0;
            own_q     <= '0;
            own_vld_q <= 1'b0;
            used_q    <= '0;
            spent_q   <= '0;
            for (int t = 0; t < N_TIERS; t++) begin
                ptr_q[t] <= IDX_BITS'(last_of_tier(TIER_MAP, N_MASTERS, t));
            end
        end else if (decide) begin
            if (keep) begin
                used_q <= used_q + 1'b1;
            end else begin
                grant_o        <= '0;
                grant_o[win]   <= 1'b1;
                own_q          <= win;
                own_vld_q      <= 1'b1;
                used_q         <= WGT_BITS'(1);
                ptr_q[sel_t]   <= win;
                spent_q        <= spent_nx;
            end
        end else if (own_vld_q && !req_i[own_q]) begin
            grant_o   <= '0;
            own_vld_q <= 1'b0;
        end
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R2
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_free_i |=> (grant_o == $past(grant_o) || grant_o == '0));

    // R3
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_free_i && |req_i) |=> (grant_o != '0 && (grant_o & ~$past(req_i)) == '0));

    // R4
    drop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (own_vld_q && !req_i[own_q] && !bus_free_i) |=> grant_o == '0);

    // R7
    top_tier_first_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_free_i && |(req_i & TOP_MASK) && !spent_q[0]) |=> |(grant_o & TOP_MASK));

endmodule

// File: tb/tb_wrr_tier_arbiter.sv
module tb_wrr_tier_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int N = 6;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req;
    logic         bus_free;
    logic         cfg_we;
    logic [3:0]   cfg_idx;
    logic [3:0]   cfg_wdata;
    logic [N-1:0] grant;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrr_tier_arbiter dut (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .bus_free_i (bus_free),
        .cfg_we_i   (cfg_we),
        .cfg_idx_i  (cfg_idx),
        .cfg_wdata_i(cfg_wdata),
        .grant_o    (grant)
    );

    // ---------------- reference model built from the requirements ----------
    int           m_w [N];
    int           m_ptr [3];
    bit           m_spent [3];
    int           m_own;
    bit           m_vld;
    int           m_used;
    logic [N-1:0] m_grant;

    function automatic int tier(input int m);
        if (m <= 1) return 0;
        if (m <= 4) return 1;
        return 2;
    endfunction

    task automatic model_reset();
        m_w     = '{4, 2, 1, 1, 1, 1};
        m_ptr   = '{1, 4, 5};
        m_spent = '{0, 0, 0};
        m_own   = 0;
        m_vld   = 0;
        m_used  = 0;
        m_grant = '0;
    endtask

    task automatic model_step();
        bit any [3];
        bit elig [3];
        bit keep, hi, fresh, found, last;
        int sel, w, c;
        if (rst) begin
            model_reset();
        end else begin
            if (bus_free && |req) begin
                for (int t = 0; t < 3; t++) begin
                    any[t] = 0;
                    for (int m = 0; m < N; m++) if (req[m] && tier(m) == t) any[t] = 1;
                    elig[t] = any[t] && !m_spent[t];
                end
                hi = 0;
                for (int t = 0; t < 3; t++) if (t < tier(m_own) && elig[t]) hi = 1;
                keep = m_vld && req[m_own] && (m_used < m_w[m_own]) && !hi;
                if (keep) begin
                    m_used++;
                end else begin
                    fresh = !(elig[0] || elig[1] || elig[2]);
                    sel = -1;
                    for (int t = 0; t < 3; t++)
                        if (sel < 0 && (fresh ? any[t] : elig[t])) sel = t;
                    found = 0;
                    w = 0;
                    for (int off = 1; off <= N; off++) begin
                        c = (m_ptr[sel] + off) % N;
                        if (!found && req[c] && tier(c) == sel) begin
                            found = 1;
                            w = c;
                        end
                    end
                    last = 1;
                    for (int m = w + 1; m < N; m++) if (req[m] && tier(m) == sel) last = 0;
                    if (fresh) m_spent = '{0, 0, 0};
                    if (last) m_spent[sel] = 1;
                    m_ptr[sel] = w;
                    m_own   = w;
                    m_vld   = 1;
                    m_used  = 1;
                    m_grant = N'(1) << w;
                end
            end else if (m_vld && !req[m_own]) begin
                m_vld   = 0;
                m_grant = '0;
            end
            if (cfg_we && cfg_idx < 4'(N) && cfg_wdata != 0) m_w[cfg_idx] = int'(cfg_wdata);
        end
    endtask

    always @(posedge clk) model_step();

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [N-1:0] exp);
        n_chk++;
        if (grant !== exp) begin
            n_fail++;
            $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic cyc(input logic [N-1:0] r, input bit bf);
        req = r;
        bus_free = bf;
        cfg_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_weight(input int idx, input int val);
        req = '0;
        bus_free = 1'b0;
        cfg_we = 1'b1;
        cfg_idx = 4'(idx);
        cfg_wdata = 4'(val);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req = '0;
        bus_free = 1'b0;
        cfg_we = 1'b0;
        cfg_idx = '0;
        cfg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int seq_a [14] = '{0, 0, 0, 0, 1, 1, 2, 3, 4, 0, 0, 0, 0, 1};
        int seq_b [11] = '{0, 0, 0, 0, 1, 1, 2, 3, 4, 5, 0};
        int seq_g [6]  = '{0, 1, 1, 0, 1, 1};
        logic [N-1:0] rq;

        void'($urandom(32'd20240611));
        do_reset();
        // R11: reset state
        chk("R11 reset grant", '0);

        // R5 R6: default sequence with diagnostic port idle
        for (int i = 0; i < 14; i++) begin
            cyc(6'b011111, 1'b1);
            chk("R6 R5 default rotation", N'(1) << seq_a[i]);
        end

        // R6 R12: all six masters requesting
        do_reset();
        for (int i = 0; i < 11; i++) begin
            cyc(6'b111111, 1'b1);
            chk("R6 R12 full rotation", N'(1) << seq_b[i]);
        end

        // R2: hold without bus free
        do_reset();
        cyc(6'b000001, 1'b1);
        chk("R2 first grant", 6'b000001);
        for (int i = 0; i < 3; i++) begin
            cyc(6'b111111, 1'b0);
            chk("R2 hold without bus free", 6'b000001);
        end
        cyc(6'b111111, 1'b1);
        chk("R5 owner keeps within weight", 6'b000001);
        // R4: owner drops without bus free
        cyc(6'b111110, 1'b0);
        chk("R4 drop clears grant", 6'b000000);
        // R12: tier 0 finished its round when master 0 was its only requester
        cyc(6'b111110, 1'b1);
        chk("R12 finished tier steps aside", 6'b000100);

        // R8: forfeit passes the turn on
        do_reset();
        cyc(6'b000011, 1'b1);
        chk("R8 setup", 6'b000001);
        cyc(6'b000010, 1'b0);
        chk("R4 drop clears grant", 6'b000000);
        cyc(6'b000011, 1'b1);
        chk("R8 forfeit moves rotation", 6'b000010);

        // R7 R9: preemption and per-tier position
        do_reset();
        cyc(6'b011100, 1'b1);
        chk("R9 middle tier first", 6'b000100);
        cyc(6'b011101, 1'b1);
        chk("R7 higher tier preempts", 6'b000001);
        cyc(6'b011100, 1'b1);
        chk("R9 middle tier resumes", 6'b001000);

        // R10: weight programming, zero and out-of-range writes ignored
        do_reset();
        wr_weight(0, 1);
        wr_weight(1, 0);
        wr_weight(7, 3);
        for (int i = 0; i < 6; i++) begin
            cyc(6'b000011, 1'b1);
            chk("R10 R5 programmed weights", N'(1) << seq_g[i]);
        end

        // random phase against the model
        do_reset();
        rq = '0;
        for (int i = 0; i < 4000; i++) begin
            for (int m = 0; m < N; m++)
                if ($urandom % 5 == 0) rq[m] = ~rq[m];
            req = rq;
            bus_free = ($urandom % 3) != 0;
            cfg_we = ($urandom % 40) == 0;
            cfg_idx = 4'($urandom % 9);
            cfg_wdata = 4'($urandom % 16);
            @(posedge clk);
            @(negedge clk);
            chk("R3 R6 random vs model", m_grant);
            n_chk++;
            if (!$onehot0(grant)) begin
                n_fail++;
                $display("FAIL R1: grant=%b expected=one-hot or zero", grant);
            end
        end

        done = 1'b1;
        summary();
    end

endmodule